// File: doc/BRIEF.md
# Count Leading Zeros Word Unit

This block is the execute slice for a single instruction of a 64-bit register machine: count the leading zeros of the low word. Each cycle it takes a 32-bit instruction word, the 64-bit value of the source register and the current summary-overflow bit, qualified by a valid strobe. It checks whether the word encodes the count-leading-zeros-word operation. It also pulls out the source register index, the destination register index and the record flag.

Only the low 32 bits of the source are counted. The count is a value from 0 to 32. It is zero-extended to 64 bits and returned with a destination write enable. When the record flag is set, the block also produces a 4-bit condition field and a write enable for it. The field comes from a signed comparison of the result with zero, and it carries a copy of the summary-overflow bit.

The counter is a log-depth tree of small leading-zero detectors. An optional output register stage, selected by parameter, adds one cycle of latency with a matching valid output. A word that does not match the operation causes no writes.

Top module: `clzw_unit`

## Requirements
- R1: The word is recognised only when instr[31:26] equals 31 and instr[10:1] equals 26. The field instr[15:11] is ignored and never changes the decode (the all-zero-register encoding is 0x7C000034).
- R2: The source register index is instr[25:21] and is presented combinationally on `src_idx`. The destination index is instr[20:16] and is returned on `dst_idx`. The record flag is instr[0].
- R3: Bits 63:32 of the source value have no effect on any output.
- R4: When the low 32 bits of the source are all zero, the count is 32, whatever the upper half holds.
- R5: When bit 31 of the source is set, the count is 0.
- R6: `result` equals the number of leading zero bits of the low word, zero-extended. Bits 63:6 of `result` are always zero.
- R7: The condition field is laid out as bit 3 LT, bit 2 GT, bit 1 EQ and bit 0 summary overflow. LT is always 0. EQ is 1 only for a count of 0, and GT is 1 otherwise. Bit 0 copies `so_in`.
- R8: `cr_we` is 1 only for a valid, recognised word whose record flag is 1.
- R9: `dst_we` is 1 only for a valid, recognised word. An unrecognised word, or a cycle without `in_valid`, produces neither write enable.
- R10: With the default register stage, outputs appear one clock after the input cycle. `out_valid` follows `in_valid` with one cycle of delay. Reset clears `out_valid`, `dst_we` and `cr_we`.
- R11: For every nonzero low word, 31 minus the count equals the index of its highest set bit (floor of log2).

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| src_value | input | 64 | Value of the source register |
| so_in | input | 1 | Current summary-overflow bit |
| src_idx | output | 5 | Source register index for the register file read |
| out_valid | output | 1 | Output slot is occupied |
| dst_we | output | 1 | Destination register write enable |
| dst_idx | output | 5 | Destination register index |
| result | output | 64 | Zero-extended leading-zero count |
| cr_we | output | 1 | Condition field 0 write enable |
| cr_field | output | 4 | New condition field value {LT, GT, EQ, SO} |

## Verification
The destination write and the condition-field write coincide in the same output cycle whenever a recognised record-form word arrives. That is also the only case where both enables rise together. The bench provokes this by setting the record flag on sources whose count is 0, a middle value and 32, with the summary-overflow input both low and high. In that one sampled cycle it judges that both enables are high, that the result matches the reference count, and that EQ and GT follow that same count. With the record flag clear it confirms that the condition enable stays low while the destination write still occurs.

// File: rtl/clzw_pkg.sv
package clzw_pkg;

  localparam int unsigned REG_IDX_W = 5;
  localparam logic [5:0]  PRIMARY_OP = 6'd31;
  localparam logic [9:0]  EXTENDED_OP = 10'd26;

  typedef struct packed {
    logic                 hit;
    logic [REG_IDX_W-1:0] src_idx;
    logic [REG_IDX_W-1:0] dst_idx;
    logic                 rec;
  } clzw_dec_t;

endpackage

// File: rtl/clzw_decode.sv
module clzw_decode
  import clzw_pkg::*;
(
  input  logic [31:0] instr,
  output clzw_dec_t   dec
);

  // instr[15:11] is the unused third-operand field; it takes no part in the decode
  logic unused_bfield;
  assign unused_bfield = ^instr[15:11];

  always_comb begin
    dec         = '0;
    dec.hit     = (instr[31:26] == PRIMARY_OP) && (instr[10:1] == EXTENDED_OP);
    dec.src_idx = instr[25:21];
    dec.dst_idx = instr[20:16];
    dec.rec     = instr[0];
  end

endmodule

// File: rtl/clzw_lzc.sv
module clzw_lzc #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GROUP = 4,
  localparam int unsigned CW     = $clog2(WIDTH) + 1,
  localparam int unsigned NLEAF  = WIDTH / GROUP,
  localparam int unsigned LEVELS = $clog2(NLEAF),
  localparam int unsigned NNODE  = 2 * NLEAF - 1
) (
  input  logic [WIDTH-1:0] data_in,
  output logic [CW-1:0]    count
);

  // Heap-ordered tree: node 0 is the root, leaves sit at NLEAF-1 .. NNODE-1,
  // the lowest leaf number covering the most significant group.
  logic [CW-1:0] node_cnt [NNODE];
  logic          node_z   [NNODE];

  for (genvar j = 0; j < NLEAF; j++) begin : g_leaf
    localparam int unsigned LO = WIDTH - GROUP * (j + 1);
    logic [GROUP-1:0] grp;
    logic [CW-1:0]    leaf_cnt;
    assign grp = data_in[LO +: GROUP];
    always_comb begin
      leaf_cnt = CW'(GROUP);
      for (int b = 0; b < GROUP; b++) begin
        if (grp[b]) leaf_cnt = CW'(GROUP - 1 - b);
      end
    end
    assign node_cnt[NLEAF - 1 + j] = leaf_cnt;
    assign node_z[NLEAF - 1 + j]   = ~|grp;
  end

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
    localparam int unsigned HALF = WIDTH >> (lvl + 1);
    for (genvar j = 0; j < (1 << lvl); j++) begin : g_node
      localparam int unsigned K = (1 << lvl) - 1 + j;
      assign node_z[K]   = node_z[2*K+1] & node_z[2*K+2];
      assign node_cnt[K] = node_z[2*K+1] ? (CW'(HALF) + node_cnt[2*K+2])
                                         : node_cnt[2*K+1];
    end
  end

  assign count = node_cnt[0];

endmodule

// File: rtl/clzw_crfield.sv
module clzw_crfield #(
  parameter int unsigned CW = 6
) (
  input  logic [CW-1:0] count,
  input  logic          so_in,
  output logic [3:0]    field
);

  logic lt, gt, eq;

  always_comb begin
    // The count is zero-extended, so its signed view is never below zero
    lt = $signed({1'b0, count}) < 0;
    eq = (count == '0);
    gt = !lt && !eq;
    field = {lt, gt, eq, so_in};
  end

endmodule

// File: rtl/clzw_unit.sv
module clzw_unit
  import clzw_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned WORD  = 32,
  parameter int unsigned GROUP = 4,
  parameter bit          PIPE  = 1'b1,
  localparam int unsigned CW   = $clog2(WORD) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [31:0]          instr,
  input  logic [XLEN-1:0]      src_value,
  input  logic                 so_in,
  output logic [REG_IDX_W-1:0] src_idx,
  output logic                 out_valid,
  output logic                 dst_we,
  output logic [REG_IDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]      result,
  output logic                 cr_we,
  output logic [3:0]           cr_field
);

  clzw_dec_t     dec;
  logic [CW-1:0] cnt;
  logic [3:0]    crf;
  logic          unused_upper;

  assign unused_upper = ^src_value[XLEN-1:WORD];

  clzw_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  assign src_idx = dec.src_idx;

  clzw_lzc #(.WIDTH(WORD), .GROUP(GROUP)) u_lzc (
    .data_in (src_value[WORD-1:0]),
    .count   (cnt)
  );

  clzw_crfield #(.CW(CW)) u_crfield (
    .count (cnt),
    .so_in (so_in),
    .field (crf)
  );

  // next-state values
  logic                 nxt_valid, nxt_dst_we, nxt_cr_we;
  logic [REG_IDX_W-1:0] nxt_dst_idx;
  logic [XLEN-1:0]      nxt_result;
  logic [3:0]           nxt_cr_field;

  always_comb begin
    nxt_valid    = in_valid;
    nxt_dst_we   = in_valid && dec.hit;
    nxt_cr_we    = in_valid && dec.hit && dec.rec;
    nxt_dst_idx  = dec.dst_idx;
    nxt_result   = XLEN'(cnt);
    nxt_cr_field = crf;
  end

  if (PIPE) begin : g_pipe
    logic                 q_valid, q_dst_we, q_cr_we;
    logic [REG_IDX_W-1:0] q_dst_idx;
    logic [XLEN-1:0]      q_result;
    logic [3:0]           q_cr_field;
    logic                 load_en;

    assign load_en = in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_valid  <= 1'b0;
        q_dst_we <= 1'b0;
        q_cr_we  <= 1'b0;
      end else begin
        q_valid  <= nxt_valid;
        q_dst_we <= nxt_dst_we;
        q_cr_we  <= nxt_cr_we;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_dst_idx  <= '0;
        q_result   <= '0;
        q_cr_field <= '0;
      end else if (load_en) begin
        q_dst_idx  <= nxt_dst_idx;
        q_result   <= nxt_result;
        q_cr_field <= nxt_cr_field;
      end
    end

    assign out_valid = q_valid;
    assign dst_we    = q_dst_we;
    assign cr_we     = q_cr_we;
    assign dst_idx   = q_dst_idx;
    assign result    = q_result;
    assign cr_field  = q_cr_field;
  end else begin : g_comb
    assign out_valid = nxt_valid;
    assign dst_we    = nxt_dst_we;
    assign cr_we     = nxt_cr_we;
    assign dst_idx   = nxt_dst_idx;
    assign result    = nxt_result;
    assign cr_field  = nxt_cr_field;
  end

  // counter tree boundary behaviour, seen at its input and output
  p_zero_low_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_value[WORD-1:0] == '0) |-> (cnt == CW'(WORD)));

  p_sign_bit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_value[WORD-1] |-> (cnt == '0));

  // output-side relations
  p_high_bits_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (result[XLEN-1:CW] == '0));

  p_eq_tracks_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ((cr_field[1] == (result == '0)) && !cr_field[3]
               && (cr_field[2] == (result != '0))));

  p_cr_needs_dst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> dst_we);

  p_we_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> out_valid);

endmodule

// File: tb/test_clzw_unit.sv
`timescale 1ns/1ps
module test_clzw_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] src_value;
  logic        so_in;
  logic [4:0]  src_idx;
  logic        out_valid, dst_we, cr_we;
  logic [4:0]  dst_idx;
  logic [63:0] result;
  logic [3:0]  cr_field;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  clzw_unit i_clzw_unit (
    .clk, .rst_n, .in_valid, .instr, .src_value, .so_in,
    .src_idx, .out_valid, .dst_we, .dst_idx, .result, .cr_we, .cr_field
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ref_clz(input logic [31:0] w);
    int n = 0;
    for (int b = 31; b >= 0; b--) begin
      if (w[b]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int ref_log2(input logic [31:0] w);
    int h = -1;
    for (int b = 0; b < 32; b++) if (w[b]) h = b;
    return h;
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] s, input logic [4:0] d,
                                     input logic [4:0] bf, input logic rec);
    return {6'd31, s, d, bf, 10'd26, rec};
  endfunction

  // Apply one word for one cycle and check everything at the registered output.
  task automatic run_one(input logic [31:0] w, input logic [63:0] v, input logic so,
                         input bit exp_hit);
    int          c;
    bit          rec;
    logic [3:0]  exp_cr;
    @(negedge clk);
    instr = w; src_value = v; so_in = so; in_valid = 1'b1;
    #1;
    check(src_idx == w[25:21], "R2 src_idx", 64'(src_idx), 64'(w[25:21]));
    check(out_valid == 1'b0, "R10 no output before edge", 64'(out_valid), 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    c   = ref_clz(v[31:0]);
    rec = w[0];
    exp_cr = {1'b0, c != 0, c == 0, so};
    check(out_valid == 1'b1, "R10 out_valid one cycle later", 64'(out_valid), 64'd1);
    check(dst_we == exp_hit, "R9 dst_we", 64'(dst_we), 64'(exp_hit));
    check(cr_we == (exp_hit && rec), "R8 cr_we", 64'(cr_we), 64'(exp_hit && rec));
    if (exp_hit) begin
      check(result == 64'(c), "R6 result count", result, 64'(c));
      check(dst_idx == w[20:16], "R2 dst_idx", 64'(dst_idx), 64'(w[20:16]));
      if (rec) check(cr_field == exp_cr, "R7 cr_field", 64'(cr_field), 64'(exp_cr));
      if (v[31:0] != 0)
        check(31 - int'(result) == ref_log2(v[31:0]), "R11 floor log2",
              64'(31 - int'(result)), 64'(ref_log2(v[31:0])));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_value = '0; so_in = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && dst_we == 0 && cr_we == 0, "R10 reset state",
          {61'd0, out_valid, dst_we, cr_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_single_bits();
    for (int i = 0; i <= 32; i++) begin
      logic [31:0] lo = (i == 32) ? 32'd0 : (32'd1 << i);
      run_one(mk(5'(i), 5'(31 - i % 32), 5'd0, 1'b1), {$urandom(), lo}, i[0], 1'b1);
    end
  endtask

  task automatic t_low_zero();
    for (int i = 0; i < 12; i++) begin
      logic [31:0] hi = $urandom() | 32'h1;
      run_one(mk(5'd3, 5'd4, 5'd0, 1'b1), {hi, 32'd0}, 1'b0, 1'b1);
      check(result == 64'd32, "R4 count 32 with nonzero upper", result, 64'd32);
    end
  endtask

  task automatic t_sign_bit();
    for (int i = 0; i < 8; i++) begin
      run_one(mk(5'd1, 5'd2, 5'd0, 1'b1), {$urandom(), 32'h8000_0000 | $urandom()},
              1'b1, 1'b1);
      check(result == 64'd0, "R5 count 0 with sign bit", result, 64'd0);
      check(cr_field == 4'b0011, "R7 EQ and SO", 64'(cr_field), 64'h3);
    end
  endtask

  task automatic t_upper_ignored();
    for (int i = 0; i < 10; i++) begin
      logic [31:0] lo = $urandom() >> (i * 3);
      logic [63:0] first;
      logic [3:0]  first_cr;
      run_one(mk(5'd7, 5'd9, 5'd0, 1'b1), {32'd0, lo}, 1'b0, 1'b1);
      first = result; first_cr = cr_field;
      run_one(mk(5'd7, 5'd9, 5'd0, 1'b1), {$urandom() | 32'h8000_0000, lo}, 1'b0, 1'b1);
      check(result == first && cr_field == first_cr, "R3 upper half ignored",
            result, first);
    end
  endtask

  task automatic t_decode();
    // B field nonzero still decodes
    run_one(mk(5'd2, 5'd5, 5'd17, 1'b0), 64'h0000_0000_0001_0000, 1'b0, 1'b1);
    check(dst_we == 1'b1, "R1 B field ignored", 64'(dst_we), 64'd1);
    check(cr_we == 1'b0, "R8 no cr without record flag", 64'(cr_we), 64'd0);
    run_one(32'h7C00_0034, 64'd1, 1'b0, 1'b1);
    check(dst_we == 1'b1, "R1 base encoding", 64'(dst_we), 64'd1);
    // wrong primary opcode
    run_one({6'd30, 20'd0, 5'd0, 1'b1} | 32'h0000_0034, 64'd5, 1'b1, 1'b0);
    check(dst_we == 0 && cr_we == 0, "R1 wrong primary", 64'(dst_we), 64'd0);
    // wrong extended opcodes
    run_one({6'd31, 15'd0, 10'd58, 1'b1}, 64'd5, 1'b1, 1'b0);
    run_one({6'd31, 15'd0, 10'd27, 1'b1}, 64'd5, 1'b1, 1'b0);
    check(dst_we == 0 && cr_we == 0, "R1 wrong extended", 64'(cr_we), 64'd0);
  endtask

  task automatic t_no_valid();
    @(negedge clk);
    instr = mk(5'd1, 5'd1, 5'd0, 1'b1); src_value = 64'd1; in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && dst_we == 0 && cr_we == 0, "R9 idle cycle no writes",
          {61'd0, out_valid, dst_we, cr_we}, 64'd0);
  endtask

  task automatic t_record_both();
    logic [31:0] pats [3] = '{32'h8000_0000, 32'h0000_1000, 32'h0};
    for (int i = 0; i < 3; i++) begin
      for (int s = 0; s < 2; s++) begin
        run_one(mk(5'd8, 5'd10, 5'd0, 1'b1), {32'hFFFF_FFFF, pats[i]}, s[0], 1'b1);
        check(dst_we && cr_we, "R8 both writes together", {62'd0, dst_we, cr_we}, 64'd3);
        check(cr_field[0] == s[0], "R7 SO copy", 64'(cr_field[0]), 64'(s));
      end
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      logic [31:0] lo = $urandom() >> ($urandom() % 32);
      run_one(mk(5'($urandom()), 5'($urandom()), 5'($urandom()), 1'($urandom())),
              {$urandom(), lo}, 1'($urandom()), 1'b1);
    end
  endtask

  initial begin
    t_reset();
    t_single_bits();
    t_low_zero();
    t_sign_bit();
    t_upper_ignored();
    t_decode();
    t_no_valid();
    t_record_both();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule